// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block sits between a host register port and an analog input multiplexer. It keeps two 5-bit channel bounds that define a scan window over 32 inputs, and a live channel pointer that steers the multiplexer. Each accepted start request produces a one-cycle pulse to the converter. From that pulse until the converter reports completion, the block is busy. When the conversion completes, the pointer steps to the next channel in the window.

A start can come from two places: a host write to the start address, or a rising edge on an external trigger input when external triggering is selected. The trigger input is synchronized before use. While a conversion is in flight, every new request is discarded and none is queued. A status word gives the busy flag and the live pointer. Loading the lower bound also rewinds the pointer, so software can restart a scan from a known channel.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, the lower bound, upper bound and pointer are 0, busy is 0, and `conv_start_o` is 0.
- R2: A write with `wr_addr_i`=1 sets the lower bound, and a write with `wr_addr_i`=2 sets the upper bound, both from `wr_data_i[4:0]`. Reading address 1 or 2 returns the stored bound in bits 4..0, with bits 7..5 at zero.
- R3: A lower-bound write loads the same value into the pointer (`mux_chan_o`) at the next clock edge. It wins over a pointer advance in the same cycle.
- R4: A write with `wr_addr_i`=0 while idle, with any data, produces `conv_start_o` high for exactly one cycle, starting at the next clock edge. Busy goes high at that same edge.
- R5: Busy stays high until `conv_done_i` is sampled high while busy, and clears at the following edge. `conv_done_i` has no effect while idle.
- R6: A start request, from software or from the trigger, that arrives while busy is dropped. It produces no pulse, and it is not remembered.
- R7: A software start is accepted whether `ext_trig_sel_i` is 0 or 1.
- R8: With `ext_trig_sel_i`=1, a rising edge on `ext_trig_i` produces exactly one start pulse. The pulse arrives three edges after the input changes, because of two synchronizer stages and one register stage.
- R9: With `ext_trig_sel_i`=0, edges on `ext_trig_i` produce no start pulse.
- R10: When a conversion completes, the pointer moves to the lower bound if it equals the upper bound. Otherwise it moves to pointer+1, modulo 32. The pointer is otherwise unchanged, except by R3.
- R11: Reading address 3 returns busy in bit 7 and the pointer in bits 4..0, with bits 6..5 at zero.
- R12: A software start and a trigger edge that arrive in the same idle cycle give a single start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 start, 1 lower bound, 2 upper bound |
| wr_data_i | input | 5 | Write data (a channel number) |
| rd_addr_i | input | 2 | Read address: 1 lower bound, 2 upper bound, 3 status |
| rd_data_o | output | 8 | Combinational read data |
| ext_trig_sel_i | input | 1 | Enables starts from the external trigger |
| ext_trig_i | input | 1 | Asynchronous external trigger |
| conv_done_i | input | 1 | Converter completion strobe |
| conv_start_o | output | 1 | One-cycle conversion start pulse |
| mux_chan_o | output | 5 | Live channel pointer to the input multiplexer |

## Verification
The assertions check the following on every cycle:
- a start pulse always comes with busy set, and it never lasts two cycles;
- no pulse appears without a request;
- busy clears after a completion;
- the pointer follows a lower-bound write or a completion step, and otherwise holds;
- the upper read-back bits stay zero.

Other behaviours can only be shown by the bench's scenarios. These include the exact synchronizer latency of a trigger edge, and the fact that a dropped request is truly forgotten and never served later. They also include the merging of simultaneous software and trigger starts, and the wrap cases where the window bounds are inverted or sit at channel 31.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [1:0] {
    ADDR_START = 2'd0,
    ADDR_LO    = 2'd1,
    ADDR_HI    = 2'd2,
    ADDR_STAT  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/adc_scan_trig_sync.sv
module adc_scan_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= trig_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], trig_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/adc_scan_start_arb.sv
module adc_scan_start_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_req_i,
  input  logic trig_req_i,
  input  logic done_i,
  output logic start_o,
  output logic busy_o,
  output logic adv_o
);
  logic start_q, busy_q, accept;

  // requests while busy are dropped, not queued
  assign accept = (sw_req_i | trig_req_i) & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      start_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      start_q <= accept;
      if (accept)               busy_q <= 1'b1;
      else if (busy_q && done_i) busy_q <= 1'b0;
    end

  assign start_o = start_q;
  assign busy_o  = busy_q;
  assign adv_o   = busy_q & done_i;
endmodule

// File: rtl/adc_scan_chan_regs.sv
module adc_scan_chan_regs #(
  parameter int CH_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lo_we_i,
  input  logic            hi_we_i,
  input  logic [CH_W-1:0] wdata_i,
  input  logic            adv_i,
  output logic [CH_W-1:0] lo_o,
  output logic [CH_W-1:0] hi_o,
  output logic [CH_W-1:0] ptr_o
);
  logic [CH_W-1:0] lo_q, hi_q, ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      lo_q  <= '0;
      hi_q  <= '0;
      ptr_q <= '0;
    end else begin
      if (lo_we_i) lo_q <= wdata_i;
      if (hi_we_i) hi_q <= wdata_i;
      // lower-bound write rewinds the pointer and wins over a step
      if (lo_we_i)       ptr_q <= wdata_i;
      else if (adv_i)    ptr_q <= (ptr_q == hi_q) ? lo_q : ptr_q + 1'b1;
    end

  assign lo_o  = lo_q;
  assign hi_o  = hi_q;
  assign ptr_o = ptr_q;
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int CH_W        = 5,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_addr_i,
  input  logic [CH_W-1:0] wr_data_i,
  input  logic [1:0]      rd_addr_i,
  output logic [DW-1:0]   rd_data_o,
  input  logic            ext_trig_sel_i,
  input  logic            ext_trig_i,
  input  logic            conv_done_i,
  output logic            conv_start_o,
  output logic [CH_W-1:0] mux_chan_o
);
  import adc_scan_pkg::*;

  localparam int BUSY_BIT = DW - 1;

  logic            sw_req, lo_we, hi_we, trig_rise, adv, busy;
  logic [CH_W-1:0] lo_ch, hi_ch;

  assign sw_req = wr_en_i && (wr_addr_i == ADDR_START);
  assign lo_we  = wr_en_i && (wr_addr_i == ADDR_LO);
  assign hi_we  = wr_en_i && (wr_addr_i == ADDR_HI);

  adc_scan_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .trig_i (ext_trig_i), .rise_o (trig_rise)
  );

  adc_scan_start_arb u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sw_req_i   (sw_req),
    .trig_req_i (trig_rise & ext_trig_sel_i),
    .done_i     (conv_done_i),
    .start_o    (conv_start_o),
    .busy_o     (busy),
    .adv_o      (adv)
  );

  adc_scan_chan_regs #(.CH_W(CH_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lo_we_i (lo_we),
    .hi_we_i (hi_we),
    .wdata_i (wr_data_i),
    .adv_i   (adv),
    .lo_o    (lo_ch),
    .hi_o    (hi_ch),
    .ptr_o   (mux_chan_o)
  );

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      ADDR_LO:   rd_data_o[CH_W-1:0] = lo_ch;
      ADDR_HI:   rd_data_o[CH_W-1:0] = hi_ch;
      ADDR_STAT: begin
        rd_data_o[CH_W-1:0] = mux_chan_o;
        rd_data_o[BUSY_BIT] = busy;
      end
      default:   rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int CH_W = 5,
  parameter int DW   = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic [1:0]      wr_addr_i,
  input logic [CH_W-1:0] wr_data_i,
  input logic [1:0]      rd_addr_i,
  input logic [DW-1:0]   rd_data_o,
  input logic            ext_trig_sel_i,
  input logic            conv_done_i,
  input logic            conv_start_o,
  input logic [CH_W-1:0] mux_chan_o,
  input logic            busy,
  input logic [CH_W-1:0] lo_ch,
  input logic [CH_W-1:0] hi_ch
);
  logic lo_wr, sw_st;
  assign lo_wr = wr_en_i && (wr_addr_i == 2'd1);
  assign sw_st = wr_en_i && (wr_addr_i == 2'd0);

  // R4
  start_with_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> busy);
  // R6
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);
  // R6
  busy_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !conv_done_i) |=> !conv_start_o);
  // R5
  done_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && conv_done_i) |=> (!busy || conv_start_o));
  // R5
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> conv_start_o);
  // R9
  no_trig_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_st && !ext_trig_sel_i) |=> !conv_start_o);
  // R3
  lo_loads_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_wr |=> mux_chan_o == $past(wr_data_i));
  // R10
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && conv_done_i && !lo_wr) |=> mux_chan_o ==
      (($past(mux_chan_o) == $past(hi_ch)) ? $past(lo_ch) : CH_W'($past(mux_chan_o) + 1'b1)));
  // R10
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(busy && conv_done_i) && !lo_wr) |=> $stable(mux_chan_o));
  // R2
  readback_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == 2'd1 || rd_addr_i == 2'd2) |-> rd_data_o[DW-1:CH_W] == '0);
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.CH_W(CH_W), .DW(DW)) u_chk (.*);

// File: tb/sim_adc_scan_seq.sv
`timescale 1ns/1ps
module sim_adc_scan_seq;
  localparam int CLK_NS = 10;

  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, sel = 0, trig = 0, done = 0;
  logic [1:0] wr_addr = 0, rd_addr = 2'd3;
  logic [4:0] wr_data = 0;
  logic [7:0] rd_data;
  logic       start;
  logic [4:0] chan;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [4:0] m_lo = 0, m_hi = 0, m_ptr = 0;
  logic       m_busy = 0;

  always #(CLK_NS/2) clk = ~clk;

  adc_scan_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .ext_trig_sel_i(sel), .ext_trig_i(trig), .conv_done_i(done),
    .conv_start_o(start), .mux_chan_o(chan)
  );

  function automatic logic [4:0] nxt(logic [4:0] p, logic [4:0] lo, logic [4:0] hi);
    return (p == hi) ? lo : p + 5'd1;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive one cycle, update the model, check after the edge
  task automatic step(logic we, logic [1:0] a, logic [4:0] d, logic dn, string tag);
    logic acc, nbusy;
    logic [4:0] nptr;
    wr_en = we; wr_addr = a; wr_data = d; done = dn;
    acc   = we && a == 2'd0 && !m_busy;
    nbusy = acc ? 1'b1 : (m_busy && dn) ? 1'b0 : m_busy;
    nptr  = (we && a == 2'd1) ? d : (m_busy && dn) ? nxt(m_ptr, m_lo, m_hi) : m_ptr;
    if (we && a == 2'd1) m_lo = d;
    if (we && a == 2'd2) m_hi = d;
    m_ptr = nptr; m_busy = nbusy;
    @(posedge clk); #1;
    wr_en = 0; done = 0;
    rd_addr = 2'd3; #1;
    chk({tag, " start R4"}, start, acc);
    chk({tag, " ptr R10"}, chan, m_ptr);
    chk({tag, " status R11"}, rd_data, {m_busy, 2'b00, m_ptr});
  endtask

  // count pulses over n cycles with no other stimulus
  task automatic count_pulses(int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (start) cnt++;
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt;
    int unsigned seed;
    seed = $urandom(32'h1d5c);
    repeat (3) @(posedge clk);
    #1;
    chk("reset start R1", start, 0);
    chk("reset ptr R1", chan, 0);
    chk("reset status R1", rd_data, 0);
    rst_n = 1;
    @(posedge clk); #1;

    // R2 / R3: bounds and rewind
    step(1, 2'd1, 5'd7, 0, "lo write R3");
    step(1, 2'd2, 5'd9, 0, "hi write R2");
    rd_addr = 2'd1; #1; chk("lo readback R2", rd_data, 8'd7);
    rd_addr = 2'd2; #1; chk("hi readback R2", rd_data, 8'd9);
    rd_addr = 2'd3;

    // R4/R5/R10: scan 7..9 and wrap to 7
    for (int k = 0; k < 4; k++) begin
      step(1, 2'd0, 5'(k * 11), 0, "sw start R4");
      step(0, 2'd0, 0, 0, "hold R5");
      step(1, 2'd0, 5'd31, 1, "busy drop+done R6");
    end
    chk("wrap R10", chan, 5'd8);
    step(0, 2'd0, 0, 1, "idle done R5");

    // R10: upper bound 31 and inverted window
    step(1, 2'd1, 5'd31, 0, "lo=31 R3");
    step(1, 2'd2, 5'd31, 0, "hi=31 R2");
    step(1, 2'd0, 0, 0, "start R4");
    step(0, 2'd0, 0, 1, "done at 31 R10");
    step(1, 2'd1, 5'd30, 0, "lo=30 R3");
    step(1, 2'd2, 5'd1, 0, "hi=1 R2");
    step(1, 2'd0, 0, 0, "start R4");
    step(1, 2'd1, 5'd3, 1, "lo write vs done R3");

    // R7: sw start with trigger mode selected
    sel = 1;
    step(1, 2'd0, 5'd5, 0, "sw start sel=1 R7");
    step(0, 2'd0, 0, 1, "done R5");

    // R8: trigger edge gives one pulse
    trig = 1;
    count_pulses(2, cnt); chk("trig latency R8", cnt, 0);
    count_pulses(1, cnt); chk("trig pulse R8", cnt, 1);
    count_pulses(4, cnt); chk("trig single R8", cnt, 0);
    m_busy = 1;
    step(0, 2'd0, 0, 1, "trig done R8");

    // R6: trigger edge while busy is dropped
    trig = 0;
    step(1, 2'd0, 0, 0, "start R4");
    trig = 1;
    count_pulses(5, cnt); chk("trig while busy R6", cnt, 0);
    step(0, 2'd0, 0, 1, "done R5");
    count_pulses(4, cnt); chk("no replay R6", cnt, 0);

    // R9: trigger edge ignored when deselected
    trig = 0; sel = 0;
    count_pulses(4, cnt);
    trig = 1;
    count_pulses(6, cnt); chk("trig deselected R9", cnt, 0);

    // R12: sw start and trigger edge in the same cycle
    trig = 0; sel = 1;
    count_pulses(4, cnt);
    trig = 1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    wr_en = 1; wr_addr = 2'd0;
    @(posedge clk); #1;
    wr_en = 0;
    cnt = start ? 1 : 0;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      if (start) cnt++;
    end
    chk("merged start R12", cnt, 1);
    m_busy = 1;
    step(0, 2'd0, 0, 1, "done R5");
    trig = 0;
    count_pulses(4, cnt);

    // constrained random mix
    for (int it = 0; it < 600; it++) begin
      int op;
      op  = $urandom_range(0, 9);
      sel = 1'($urandom_range(0, 1));
      case (op)
        0, 1: step(1, 2'd1, 5'($urandom_range(0, 31)), 1'($urandom_range(0, 1)), "rnd lo R3");
        2:    step(1, 2'd2, 5'($urandom_range(0, 31)), 1'($urandom_range(0, 1)), "rnd hi R2");
        3, 4: step(1, 2'd0, 5'($urandom_range(0, 31)), 1'($urandom_range(0, 1)), "rnd start R7");
        5, 6, 7: step(0, 2'd0, 0, 1, "rnd done R10");
        default: step(0, 2'd0, 0, 0, "rnd idle R5");
      endcase
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule